// File: doc/BRIEF.md
# DMA Write Handshake Capture Unit

This block is the device-side receiver for an asynchronous DMA write. An external DMA controller writes 16-bit words into the device over an active-low handshake. The device drives a request line low when its internal sink can take a word, and the controller answers by pulling an acknowledge line low.

The acknowledge is asynchronous to the device clock. It passes through a two-flop synchronizer, and its assertion is latched so that even a short pulse starts a cycle. The block does not use the acknowledge edges as data strobes. It counts rising clock edges from the assertion and samples the data bus on the third edge. It then hands the word to the internal sink with a one-cycle valid strobe. If the acknowledge is held low past the sample point, the block holds off the next request until the synchronized acknowledge is seen released. The sample point does not move.

Top module: `dmaWriteCapture`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first cycle after it, `reqN` is 1 (request not asserted) and `wordValid` is 0.
- R2: `reqN` goes low only after a clock edge at which `sinkReady` was 1, no cycle was in progress and the synchronized acknowledge was released. It stays 1 for as long as `sinkReady` is 0.
- R3: Once the acknowledge is latched, `reqN` returns to 1. The latch happens on the second rising edge after `ackN` falls. `reqN` stays at 1 until a new cycle begins.
- R4: `dataIn` is sampled on the third rising edge after `ackN` falls (with the default `SAMPLE_EDGE` = 3). After that edge, `wordValid` is 1 for exactly one cycle and `wordData` holds the sampled word.
- R5: An acknowledge pulse that is low across only the first rising edge after it falls still produces a capture at the usual sample edge.
- R6: An acknowledge held low for many cycles does not move the sample point. `reqN` stays 1 while `ackN` stays low. With `sinkReady` at 1, `reqN` goes low again on the third rising edge after `ackN` rises.
- R7: The rising (releasing) edge of `ackN` never captures data. Each acknowledge yields exactly one `wordValid` pulse.
- R8: An acknowledge that arrives while `reqN` is 1 produces no `wordValid` pulse.
- R9: `wordData` changes only in the cycle in which `wordValid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous reset, active high |
| sinkReady | input | 1 | Internal sink can accept a word |
| ackN | input | 1 | Active-low acknowledge from the DMA controller, asynchronous |
| dataIn | input | 16 | Write data bus from the DMA controller |
| reqN | output | 1 | Active-low transfer request to the DMA controller |
| wordValid | output | 1 | One-cycle strobe: a captured word is on `wordData` |
| wordData | output | 16 | Captured word |

## Verification
The bench keeps the data bus at a wrong value until just before the third edge and changes it right after that edge. A design that sampled one edge early or one edge late would therefore deliver the wrong word. A one-edge acknowledge pulse catches a design that needs the synchronized level to persist. A long acknowledge exposes a design that samples on the release edge or issues a second strobe. It also exposes a design that requests again before the release has passed through both flops. An acknowledge sent with no request outstanding, and a period with the sink not ready, catch a design that reacts without a pending request.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CAP  = 2'd2,
    ST_HOLD = 2'd3
  } dmawState_t;

  typedef struct packed {
    logic captureEn;
    logic cycleOpen;
  } dmawStrobes_t;
endpackage

// File: rtl/dmawDatapath.sv
module dmawDatapath #(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ackN,
  input  logic [DATA_W-1:0]    dataIn,
  input  dmaw_pkg::dmawStrobes_t strb,
  output logic                 ackS1,
  output logic                 ackS2,
  output logic                 wordValid,
  output logic [DATA_W-1:0]    wordData
);
  logic               syncA;
  logic               syncB;
  logic               validQ;
  logic [DATA_W-1:0]  dataQ;

  // two-flop synchronizer on the active-high form of the acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= ~ackN;
      syncB <= syncA;
    end
  end

  // capture register and valid strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      dataQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.captureEn;
      if (strb.captureEn) dataQ <= dataIn;
    end
  end

  assign ackS1     = syncA;
  assign ackS2     = syncB;
  assign wordValid = validQ;
  assign wordData  = dataQ;

  // R4: the valid strobe lasts a single cycle
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
    validQ |=> !validQ);

  // R9: word output only moves together with the strobe
  assert_data_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(dataQ) |-> validQ);

  // R4: capture happens only inside an open cycle
  assert_capture_in_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    strb.captureEn |-> strb.cycleOpen);
endmodule

// File: rtl/dmawControl.sv
module dmawControl #(
  parameter int SAMPLE_EDGE = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sinkReady,
  input  logic                   ackS1,
  input  logic                   ackS2,
  output logic                   reqN,
  output dmaw_pkg::dmawStrobes_t strb
);
  import dmaw_pkg::*;

  localparam int CNT_W = (SAMPLE_EDGE > 2) ? $clog2(SAMPLE_EDGE) : 1;
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SAMPLE_EDGE - 1);

  dmawState_t        stateQ;
  logic              reqNQ;
  logic [CNT_W-1:0]  edgeCnt;
  logic              atSample;

  assign atSample = (stateQ == ST_CAP) && (edgeCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      reqNQ   <= 1'b1;
      edgeCnt <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (sinkReady && !ackS2) begin
            stateQ <= ST_REQ;
            reqNQ  <= 1'b0;
          end
        end
        ST_REQ: begin
          // latch the acknowledge from the first synchronizer stage
          if (ackS1) begin
            stateQ  <= ST_CAP;
            reqNQ   <= 1'b1;
            edgeCnt <= CNT_START;
          end
        end
        ST_CAP: begin
          if (edgeCnt == CNT_LAST) begin
            stateQ  <= ST_HOLD;
            edgeCnt <= '0;
          end else begin
            edgeCnt <= edgeCnt + CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (!ackS2) begin
            if (sinkReady) begin
              stateQ <= ST_REQ;
              reqNQ  <= 1'b0;
            end else begin
              stateQ <= ST_IDLE;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign reqN           = reqNQ;
  assign strb.captureEn = atSample;
  assign strb.cycleOpen = (stateQ == ST_CAP);

  // R2: a request starts only with the sink ready
  assert_req_needs_sink_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(reqNQ) |-> $past(sinkReady));

  // R6: a request starts only with the synchronized acknowledge released
  assert_req_after_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(reqNQ) |-> !$past(ackS2));

  // R3: no request is outstanding while a word is being sampled
  assert_req_off_at_sample_R3: assert property (@(posedge clk) disable iff (rst)
    atSample |-> reqNQ);
endmodule

// File: rtl/dmaWriteCapture.sv
module dmaWriteCapture #(
  parameter int DATA_W      = 16,
  parameter int SAMPLE_EDGE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sinkReady,
  input  logic              ackN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              reqN,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData
);
  dmaw_pkg::dmawStrobes_t strb;
  logic ackS1;
  logic ackS2;

  dmawControl #(.SAMPLE_EDGE(SAMPLE_EDGE)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .sinkReady (sinkReady),
    .ackS1     (ackS1),
    .ackS2     (ackS2),
    .reqN      (reqN),
    .strb      (strb)
  );

  dmawDatapath #(.DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rst       (rst),
    .ackN      (ackN),
    .dataIn    (dataIn),
    .strb      (strb),
    .ackS1     (ackS1),
    .ackS2     (ackS2),
    .wordValid (wordValid),
    .wordData  (wordData)
  );
endmodule

// File: tb/sim_dmaWriteCapture.sv
`timescale 1ns/1ps
module sim_dmaWriteCapture;
  logic        clk = 1'b0;
  logic        rst;
  logic        sinkReady;
  logic        ackN;
  logic [15:0] dataIn;
  logic        reqN;
  logic        wordValid;
  logic [15:0] wordData;

  int vectors = 0;
  int misses  = 0;
  int pulses  = 0;

  always #10 clk = ~clk;

  dmaWriteCapture u0 (
    .clk(clk), .rst(rst), .sinkReady(sinkReady), .ackN(ackN),
    .dataIn(dataIn), .reqN(reqN), .wordValid(wordValid), .wordData(wordData)
  );

  always @(negedge clk) if (wordValid) pulses++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one acknowledge, data valid only around the third edge
  task automatic tBasic(input logic [15:0] word, input bit shortPulse);
    int p0;
    check(reqN == 1'b0, "R2 request pending", reqN, 0);
    p0 = pulses;
    dataIn = ~word;
    ackN = 1'b0;                       // N0
    waitN(1);                          // N1
    if (shortPulse) ackN = 1'b1;
    check(reqN == 1'b0, "R3 request still low after first edge", reqN, 0);
    check(wordValid == 1'b0, "R4 no early strobe", wordValid, 0);
    waitN(1);                          // N2
    check(reqN == 1'b1, "R3 request withdrawn after latch", reqN, 1);
    dataIn = word;
    waitN(1);                          // N3
    dataIn = ~word;
    check(wordValid == 1'b1, shortPulse ? "R5 strobe from short pulse" : "R4 strobe", wordValid, 1);
    check(wordData == word, shortPulse ? "R5 word from short pulse" : "R4 word", wordData, word);
    ackN = 1'b1;
    waitN(1);
    check(wordValid == 1'b0, "R4 strobe lasts one cycle", wordValid, 0);
    check(wordData == word, "R9 word held after strobe", wordData, word);
    waitN(4);
    check(pulses - p0 == 1, "R7 one strobe per acknowledge", pulses - p0, 1);
  endtask

  task automatic tStretch(input logic [15:0] word);
    int p0;
    p0 = pulses;
    dataIn = ~word;
    ackN = 1'b0;
    waitN(2);
    dataIn = word;
    waitN(1);
    dataIn = 16'hDEAD;
    check(wordValid == 1'b1 && wordData == word, "R6 sample point unchanged", wordData, word);
    waitN(7);
    check(reqN == 1'b1, "R6 request held off while ack low", reqN, 1);
    ackN = 1'b1;                       // release
    waitN(2);
    check(reqN == 1'b1, "R6 request still off two edges after release", reqN, 1);
    waitN(1);
    check(reqN == 1'b0, "R6 request back on third edge after release", reqN, 0);
    check(pulses - p0 == 1, "R7 no capture on release", pulses - p0, 1);
    check(wordData == word, "R9 word unchanged without strobe", wordData, word);
  endtask

  task automatic tNoRequest();
    int p0;
    p0 = pulses;
    waitN(3);
    check(reqN == 1'b1, "R2 no request with sink not ready", reqN, 1);
    ackN = 1'b0;
    waitN(5);
    ackN = 1'b1;
    waitN(4);
    check(pulses - p0 == 0, "R8 unrequested ack ignored", pulses - p0, 0);
    check(reqN == 1'b1, "R2 still no request", reqN, 1);
    sinkReady = 1'b1;
    waitN(1);
    check(reqN == 1'b0, "R2 request once sink ready", reqN, 0);
  endtask

  initial begin
    #(20 * 100000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst = 1'b1; sinkReady = 1'b0; ackN = 1'b1; dataIn = '0;
    waitN(3);
    check(reqN == 1'b1, "R1 request off in reset", reqN, 1);
    check(wordValid == 1'b0, "R1 strobe off in reset", wordValid, 0);
    rst = 1'b0;
    waitN(1);
    check(reqN == 1'b1 && wordValid == 1'b0, "R1 idle after reset", reqN, 1);
    tNoRequest();
    tBasic(16'hA5C3, 1'b0);
    tBasic(16'h1234, 1'b1);
    tStretch(16'h0F0F);
    tBasic(16'hFFFF, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule